// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is the serial front end of a color-sensor controller's register bank. A host on a two-wire bus (one clock line, one open-drain data line) reaches byte-wide registers through it. Both bus lines are oversampled in a fast system clock domain. The system clock must run at least 16 times faster than the bus clock. Each line goes through a two-flop synchronizer. Bus events are detected from edges of the synchronized lines: a START (or repeated START) when data falls while the clock is high, a STOP when data rises while the clock is high, and rising and falling clock edges.

The device answers to the fixed 7-bit address 0x58. A write frame sets an internal register pointer and then stores one data byte through a one-cycle write strobe. A read frame sets the pointer in a write phase, then sends a repeated START and the address with the read bit. The block then fetches the byte through a one-cycle read strobe and shifts it out MSB first. The master ends the read with a NACK. The block never drives the data line high: `sda_oe` high means the line is pulled low.

The state machine has ten states:
- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_PTR`: receiving the pointer.
- `ST_PTR_ACK`: acknowledging the pointer.
- `ST_WDATA`: receiving the data byte.
- `ST_WDATA_ACK`: acknowledging the data byte.
- `ST_RDATA`: sending the read byte.
- `ST_RDATA_ACK`: releasing the line while the master acknowledges.
- `ST_IGNORE`: deaf until the next START or STOP.

Transitions:
- Any state goes to `ST_IDLE` on a STOP.
- Any state goes to `ST_ADDR` on a START.
- The remaining transitions take place on a falling clock edge.
- `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches, otherwise to `ST_IGNORE`.
- `ST_ADDR_ACK` goes to `ST_RDATA` when the direction bit is 1, otherwise to `ST_PTR`.
- `ST_PTR` goes to `ST_PTR_ACK`, which goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, which goes to `ST_IGNORE`.
- `ST_RDATA` goes to `ST_RDATA_ACK`, which goes to `ST_IGNORE`.
- Each byte state leaves after eight bits.

Top module: `tws_regslave`

## Requirements
- R1: While `rst_n` is low (asynchronously), `sda_oe`, `reg_we` and `reg_re` are 0 and `reg_addr` is 0x00. After reset the block waits for a START.
- R2: A START or repeated START (SDA falling while SCL is high) restarts address reception at any point, even in the middle of a byte. A STOP (SDA rising while SCL is high) abandons any partial frame with no register write.
- R3: The first byte after a START carries the address in bits 7:1, MSB first, and the direction in bit 0 (1 = master reads). On a match with 0x58 the block pulls SDA low during the ninth clock. On a mismatch it gives no ACK and raises no strobe until the next START or STOP.
- R4: In a write frame (address+W, pointer, data, each ACKed), `reg_we` pulses for exactly one system clock at the SCL fall that ends the eighth data bit. At that pulse `reg_addr` equals the pointer and `reg_wdata` equals the data byte. Both bytes are received MSB first.
- R5: Only one data byte is accepted per write frame. A further byte is not acknowledged and causes no write.
- R6: After address+R is acknowledged, `reg_re` pulses for exactly one system clock at the SCL fall that ends the ACK clock. `reg_rdata` is captured in that cycle and shifted out MSB first. `sda_oe` is high only for 0 bits.
- R7: After the read byte, the block releases SDA for the master's ACK/NACK clock. It keeps SDA released, reading as all ones, until the next START or STOP.
- R8: `sda_oe` changes only while the synchronized SCL is low, never during an SCL high period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 = pull the data line low; 0 = release it |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Byte from the register bank, sampled during `reg_re` |

## Verification
A wrong state would show up at the ports within one byte time. Examples are a missed address comparison, a byte counter off by one, or an ACK state left at the wrong edge. The line would then read as a missing or extra ACK at the ninth clock, or as a read byte shifted by one bit. A write strobe would be lost, duplicated or carry the wrong pointer. The bench frames every byte from the master's side, so it catches these at the ninth clock of the affected byte. Pointer and strobe errors are caught by a scoreboard at the strobe itself, and a released-bus check catches a state machine that fails to fall deaf after a transfer.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
// Synchronizer for one bus line; also returns the value one clock older
// so that edges can be seen downstream.
module tws_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= {(STAGES + 1){INIT}};
        else
            chain <= {chain[STAGES-1:0], d};
    end

    assign q      = chain[STAGES-1];
    assign q_prev = chain[STAGES];
endmodule

// File: rtl/tws_cond.sv
// Bus event decoder working on synchronized line values.
module tws_cond (
    input  logic scl,
    input  logic scl_prev,
    input  logic sda,
    input  logic sda_prev,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    assign scl_rise = scl & ~scl_prev;
    assign scl_fall = ~scl & scl_prev;
    assign start    = scl & scl_prev & sda_prev & ~sda;
    assign stop     = scl & scl_prev & ~sda_prev & sda;
endmodule

// File: rtl/tws_regslave.sv
module tws_regslave
    import tws_pkg::*;
#(
    parameter int              DW          = 8,
    parameter int              SYNC_STAGES = 2,
    parameter logic [DW-2:0]   DEV_ADDR    = 7'h58
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);
    localparam int             CW       = $clog2(DW + 1);
    localparam logic [CW-1:0]  CNT_FULL = CW'(DW);
    localparam int             NLINES   = 2;

    logic [NLINES-1:0] line_raw, line_s, line_p;
    logic scl_s, scl_p, sda_s, sda_p;
    logic start, stop, scl_rise, scl_fall;

    tws_state_e      state, nxt;
    logic [CW-1:0]   cnt;
    logic [DW-1:0]   shreg, txreg, ptr;
    logic            rx_state, cnt_state, byte_done;

    assign line_raw = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_sync
            tws_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .d      (line_raw[g]),
                .q      (line_s[g]),
                .q_prev (line_p[g])
            );
        end
    endgenerate

    assign scl_s = line_s[1];
    assign scl_p = line_p[1];
    assign sda_s = line_s[0];
    assign sda_p = line_p[0];

    tws_cond u_cond (
        .scl      (scl_s),
        .scl_prev (scl_p),
        .sda      (sda_s),
        .sda_prev (sda_p),
        .start    (start),
        .stop     (stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    assign rx_state  = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
    assign cnt_state = rx_state || (state == ST_RDATA);
    assign byte_done = (cnt == CNT_FULL);

    // next-state decode
    always_comb begin
        nxt = state;
        if (stop) begin
            nxt = ST_IDLE;
        end else if (start) begin
            nxt = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR:      if (byte_done)
                                  nxt = (shreg[DW-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  nxt = shreg[0] ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: nxt = ST_IGNORE;
                ST_RDATA:     if (byte_done) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: nxt = ST_IGNORE;
                ST_IDLE:      nxt = ST_IDLE;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            txreg <= '0;
            ptr   <= '0;
        end else begin
            state <= nxt;
            if (start || stop) begin
                cnt <= '0;
            end else if (scl_rise && cnt_state) begin
                cnt <= cnt + 1'b1;
                if (rx_state)
                    shreg <= {shreg[DW-2:0], sda_s};
            end else if (scl_fall) begin
                if (byte_done)
                    cnt <= '0;
                if (state == ST_PTR && byte_done)
                    ptr <= shreg;
                if (state == ST_ADDR_ACK && shreg[0])
                    txreg <= reg_rdata;
                if (state == ST_RDATA && !byte_done)
                    txreg <= {txreg[DW-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = 1'b0;
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        reg_addr  = ptr;
        reg_wdata = shreg;
        unique case (state)
            ST_ADDR_ACK: begin
                sda_oe = 1'b1;
                reg_re = scl_fall && shreg[0] && !start && !stop;
            end
            ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_WDATA:  reg_we = scl_fall && byte_done && !start && !stop;
            ST_RDATA:  sda_oe = ~txreg[DW-1];
            default: ;
        endcase
    end
endmodule

// File: rtl/tws_regslave_chk.sv
module tws_regslave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic reg_we,
    input logic reg_re
);
    assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_we_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !scl_s);
    assert_no_dual_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
    assert_re_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);
    assert_re_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> !scl_s);
    assert_oe_steady_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

bind tws_regslave tws_regslave_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (scl_s),
    .sda_oe (sda_oe),
    .reg_we (reg_we),
    .reg_re (reg_re)
);

// File: tb/tws_regslave_test.sv
`timescale 1ns/1ps
module tws_regslave_test;
    localparam int Q = 8;
    localparam logic [7:0] AW = 8'hB0;
    localparam logic [7:0] AR = 8'hB1;
    localparam logic [7:0] XOR_KEY = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, reg_we, reg_re;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int failures = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    assign reg_rdata = reg_addr ^ XOR_KEY;

    tws_regslave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            logic [15:0] e;
            we_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                e = exp_q.pop_front();
                check({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
            end
        end
        if (rst_n && reg_re) re_cnt++;
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(2 * Q);
    endtask

    task automatic wr_bit(input bit b);
        sda_m = b;    wait_q(Q);
        scl_m = 1'b1; wait_q(2 * Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic rd_bit(output bit v);
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        v = sda_line; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit v;
        for (int i = 7; i >= 0; i--) wr_bit(b[i]);
        rd_bit(v);
        ack = !v;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit nack);
        bit v;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(v);
            d[i] = v;
        end
        wr_bit(nack);
    endtask

    task automatic do_write(input logic [7:0] p, input logic [7:0] d);
        bit ack;
        int w0 = we_cnt;
        bus_start;
        send_byte(AW, ack);  check(ack, "R3 address ack", ack, 1);
        send_byte(p, ack);   check(ack, "R4 pointer ack", ack, 1);
        exp_q.push_back({p, d});
        send_byte(d, ack);   check(ack, "R4 data ack", ack, 1);
        bus_stop;
        check(we_cnt == w0 + 1, "R4 one write", we_cnt - w0, 1);
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic do_read(input logic [7:0] p);
        bit ack;
        logic [7:0] d;
        logic [7:0] tail;
        int r0 = re_cnt;
        bus_start;
        send_byte(AW, ack);  check(ack, "R3 address ack (read setup)", ack, 1);
        send_byte(p, ack);   check(ack, "R4 pointer ack (read setup)", ack, 1);
        bus_start;           // repeated START
        send_byte(AR, ack);  check(ack, "R2 address ack after repeated START", ack, 1);
        recv_byte(d, 1'b1);
        check(d == (p ^ XOR_KEY), "R6 read data", d, p ^ XOR_KEY);
        check(re_cnt == r0 + 1, "R6 one read strobe", re_cnt - r0, 1);
        recv_byte(tail, 1'b1);
        check(tail == 8'hFF, "R7 bus released after read", tail, 8'hFF);
        bus_stop;
    endtask

    initial begin : main
        bit ack;
        int w0;
        logic [7:0] d;
        wait_q(4);
        check(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
        check(!reg_we && !reg_re, "R1 strobes in reset", {reg_we, reg_re}, 0);
        check(reg_addr == 8'h00, "R1 pointer in reset", reg_addr, 0);
        rst_n = 1'b1;
        wait_q(4);

        do_write(8'h04, 8'h01);
        do_write(8'h0B, 8'hA5);
        do_write(8'hFF, 8'h00);
        do_read(8'h0B);
        do_read(8'h00);
        do_read(8'hFF);

        // R3: foreign addresses get no ACK and no write
        w0 = we_cnt;
        bus_start;
        send_byte(8'hB2, ack); check(!ack, "R3 foreign address nack", ack, 0);
        send_byte(8'h10, ack); check(!ack, "R3 ignored pointer", ack, 0);
        send_byte(8'h77, ack); check(!ack, "R3 ignored data", ack, 0);
        bus_stop;
        bus_start;
        send_byte(8'h31, ack); check(!ack, "R3 foreign read nack", ack, 0);
        recv_byte(d, 1'b1);    check(d == 8'hFF, "R3 no data driven", d, 8'hFF);
        bus_stop;
        check(we_cnt == w0, "R3 no write on mismatch", we_cnt - w0, 0);

        // R2: STOP after pointer abandons the frame
        w0 = we_cnt;
        bus_start;
        send_byte(AW, ack);
        send_byte(8'h11, ack);
        bus_stop;
        check(we_cnt == w0, "R2 STOP abandons write", we_cnt - w0, 0);

        // R2: START in the middle of a byte restarts addressing
        bus_start;
        wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b0); wr_bit(1'b1);
        do_write(8'h2C, 8'h96);

        // R5: a second data byte is refused
        w0 = we_cnt;
        bus_start;
        send_byte(AW, ack);
        send_byte(8'h20, ack);
        exp_q.push_back({8'h20, 8'h5A});
        send_byte(8'h5A, ack); check(ack, "R5 first data ack", ack, 1);
        send_byte(8'hFF, ack); check(!ack, "R5 extra byte nack", ack, 0);
        bus_stop;
        check(we_cnt == w0 + 1, "R5 single write", we_cnt - w0, 1);

        // R1: asynchronous reset in the middle of an ACK clock
        bus_start;
        send_byte(AW, ack);
        for (int i = 7; i >= 0; i--) wr_bit(1'b1);
        sda_m = 1'b1; wait_q(Q);        // slave now pulls the line for the ACK
        check(sda_oe == 1'b1, "R3 ack driven before reset", sda_oe, 1);
        #3 rst_n = 1'b0;
        #1 check(sda_oe == 1'b0, "R1 async release", sda_oe, 0);
        check(reg_addr == 8'h00, "R1 pointer cleared", reg_addr, 0);
        wait_q(2);
        scl_m = 1'b1; sda_m = 1'b1;
        wait_q(4);
        rst_n = 1'b1;
        wait_q(4);
        do_write(8'h0E, 8'h3F);
        do_read(8'h0E);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog R1-timeout actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule